// File: doc/BRIEF.md
# Horizontal and Vertical Blank Generator

This block produces the blanking strobe for a video encoder's output path. A single-cycle reference pulse, `sync_ref`, marks the 50% point of each composite sync. From that pulse and the programmed line length, the block places a horizontal count origin 32 clocks ahead of the next sync midpoint. From the origin it runs a pixel counter that advances once every second clock. Two programmed counts set the horizontal blanking edges: reaching `h_start` opens the active region and reaching `h_end` closes it.

A line number supplied by the surrounding timing logic is compared against a programmed inclusive window, `v_start` to `v_end`. Every line inside that window is blanked for its whole length. The window may wrap past the last line of the field. Blanking is decided per whole line only, so half-line blanking cannot be produced.

A separate check watches the programmed active and total pixel counts. It raises `config_error` when they break the evenness rule, or the multiple-of-four rule that applies in the byte-wide (8-bit YCbCr) pixel format.

Top module: `blank_gen`

## Requirements
- R1: While `rst_n` is low, `blank` is 1, `h_count` is 0 and `config_error` is 0.
- R2: After reset and until the first count origin, `blank` stays 1 and `h_count` stays 0.
- R3: If `sync_ref` is sampled high at clock edge E, the count origin occurs at edge E + 2·`total_px` − 32 + 1. From that edge `h_count` reads 0. This places the origin 32 clocks before the next sync midpoint, when sync pulses recur every 2·`total_px` clocks.
- R4: After an origin, `h_count` advances by one every second clock, so e edges after the origin it reads floor(e/2).
- R5: On an active line, `blank` becomes 0 at the edge where `h_count` first takes the value `h_start`.
- R6: `blank` becomes 1 at the edge where `h_count` first takes the value `h_end`. When `h_start` equals `h_end`, `blank` stays 1.
- R7: A line with `v_start` ≤ `line_num` ≤ `v_end` is blanked for the whole line. `blank` is 1 at every edge at which that `line_num` is applied.
- R8: When `v_start` > `v_end`, the inactive window wraps. Lines with `line_num` ≥ `v_start` or `line_num` ≤ `v_end` are blanked.
- R9: One clock after the inputs are applied, `config_error` is 1 if `active_px` or `total_px` is odd.
- R10: With `byte_fmt` = 1, `config_error` is also 1 when either count is not a multiple of four.
- R11: `config_error` is also 1 when `total_px` < 16 or `active_px` > `total_px`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_ref | input | 1 | One-cycle pulse at the composite sync 50% point |
| line_num | input | 10 | Current line number within the field |
| h_start | input | 11 | Count at which blanking ends |
| h_end | input | 11 | Count at which blanking begins |
| v_start | input | 10 | First inactive line |
| v_end | input | 10 | Last inactive line |
| active_px | input | 11 | Active pixels per line |
| total_px | input | 11 | Total pixels per line |
| byte_fmt | input | 1 | 1 = byte-wide YCbCr pixel format |
| blank | output | 1 | Blanking strobe, 1 = blanked |
| h_count | output | 11 | Horizontal count since the origin |
| config_error | output | 1 | Line-length configuration illegal |

## Verification
Four timing configurations run for several lines each, with every cycle compared against arithmetic expectations for `blank` and `h_count`. One configuration has a plain vertical window and mid-line edges, one opens the active region at count 0, one uses equal start and end counts, and one uses a wrapping vertical window. Together they separate an origin placed at the wrong offset, a counter running at the wrong rate, swapped edge priority and a missing window wrap. An exhaustive sweep of active and total counts from 0 to 63 in both pixel formats tells the parity, multiple-of-four, minimum-length and ordering rules apart.

// File: rtl/blank_pkg.sv
`timescale 1ns/1ps
package blank_pkg;
    localparam int unsigned ZERO_LEAD_DEF = 32;
    localparam int unsigned MIN_TOTAL_DEF = 16;

    typedef enum logic {
        FMT_WIDE = 1'b0,
        FMT_BYTE = 1'b1
    } px_fmt_e;
endpackage

// File: rtl/blank_hcount.sv
`timescale 1ns/1ps
module blank_hcount #(
    parameter int unsigned PX_W      = 11,
    parameter int unsigned ZERO_LEAD = blank_pkg::ZERO_LEAD_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sync_ref,
    input  logic [PX_W-1:0] total_px,
    output logic            enter_o,
    output logic            zero_o,
    output logic            started_o,
    output logic [PX_W-1:0] cnt_next_o,
    output logic [PX_W-1:0] cnt_o
);
    localparam int unsigned POS_W = PX_W + 1;

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             run;
        logic             started;
        logic             phase;
        logic [PX_W-1:0]  cnt;
    } hc_state_t;

    hc_state_t st_q, st_d;
    logic [POS_W-1:0] zpos;
    logic             zero;
    logic             enter;

    always_comb begin
        st_d  = st_q;
        zpos  = {total_px, 1'b0} - POS_W'(ZERO_LEAD);
        zero  = st_q.run && !sync_ref && (st_q.pos == zpos);
        enter = 1'b0;
        if (sync_ref) begin
            st_d.pos = '0;
            st_d.run = 1'b1;
        end else if (st_q.pos != '1) begin
            st_d.pos = st_q.pos + 1'b1;
        end
        if (zero) begin
            st_d.cnt     = '0;
            st_d.phase   = 1'b0;
            st_d.started = 1'b1;
            enter        = 1'b1;
        end else if (st_q.started) begin
            st_d.phase = ~st_q.phase;
            if (st_q.phase && (st_q.cnt != '1)) begin
                st_d.cnt = st_q.cnt + 1'b1;
                enter    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign enter_o    = enter;
    assign zero_o     = zero;
    assign started_o  = st_q.started;
    assign cnt_next_o = st_d.cnt;
    assign cnt_o      = st_q.cnt;

    AST_HOLD_ON_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.started && !zero && !st_q.phase) |=> $stable(cnt_o)); // R4
    AST_STEP_ON_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.started && !zero && st_q.phase && (st_q.cnt != '1)) |=> (cnt_o == $past(cnt_o) + 1'b1)); // R4
    AST_IDLE_BEFORE_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.started && !zero) |=> (cnt_o == '0)); // R2
endmodule

// File: rtl/blank_vwin.sv
`timescale 1ns/1ps
module blank_vwin #(
    parameter int unsigned LINE_W = 10
) (
    input  logic [LINE_W-1:0] line_num,
    input  logic [LINE_W-1:0] v_start,
    input  logic [LINE_W-1:0] v_end,
    output logic              inactive_o
);
    logic wraps;
    logic above_lo;
    logic below_hi;

    always_comb begin
        wraps      = v_start > v_end;
        above_lo   = line_num >= v_start;
        below_hi   = line_num <= v_end;
        inactive_o = wraps ? (above_lo || below_hi) : (above_lo && below_hi);
    end
endmodule

// File: rtl/blank_cfgchk.sv
`timescale 1ns/1ps
module blank_cfgchk #(
    parameter int unsigned PX_W      = 11,
    parameter int unsigned MIN_TOTAL = blank_pkg::MIN_TOTAL_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PX_W-1:0] active_px,
    input  logic [PX_W-1:0] total_px,
    input  logic            byte_fmt,
    output logic            err_o
);
    import blank_pkg::*;

    typedef struct packed {
        logic err;
    } cfg_state_t;

    cfg_state_t st_q, st_d;
    px_fmt_e    fmt;
    logic       bad_parity;
    logic       bad_quad;
    logic       bad_len;

    always_comb begin
        st_d       = st_q;
        fmt        = px_fmt_e'(byte_fmt);
        bad_parity = active_px[0] || total_px[0];
        bad_quad   = (fmt == FMT_BYTE) && ((active_px[1:0] != 2'b00) || (total_px[1:0] != 2'b00));
        bad_len    = (total_px < PX_W'(MIN_TOTAL)) || (active_px > total_px);
        st_d.err   = bad_parity || bad_quad || bad_len;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_o = st_q.err;

    AST_ODD_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
        total_px[0] |=> err_o); // R9
    AST_BYTE_QUAD: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_fmt && total_px[1]) |=> err_o); // R10
endmodule

// File: rtl/blank_gen.sv
`timescale 1ns/1ps
module blank_gen #(
    parameter int unsigned PX_W      = 11,
    parameter int unsigned LINE_W    = 10,
    parameter int unsigned ZERO_LEAD = blank_pkg::ZERO_LEAD_DEF,
    parameter int unsigned MIN_TOTAL = blank_pkg::MIN_TOTAL_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_ref,
    input  logic [LINE_W-1:0] line_num,
    input  logic [PX_W-1:0]   h_start,
    input  logic [PX_W-1:0]   h_end,
    input  logic [LINE_W-1:0] v_start,
    input  logic [LINE_W-1:0] v_end,
    input  logic [PX_W-1:0]   active_px,
    input  logic [PX_W-1:0]   total_px,
    input  logic              byte_fmt,
    output logic              blank,
    output logic [PX_W-1:0]   h_count,
    output logic              config_error
);
    typedef struct packed {
        logic hblank;
        logic blank;
    } bl_state_t;

    bl_state_t       st_q, st_d;
    logic            enter;
    logic            zero;
    logic            started;
    logic [PX_W-1:0] cnt_next;
    logic            v_inactive;

    blank_hcount #(.PX_W(PX_W), .ZERO_LEAD(ZERO_LEAD)) u_hcount (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_ref   (sync_ref),
        .total_px   (total_px),
        .enter_o    (enter),
        .zero_o     (zero),
        .started_o  (started),
        .cnt_next_o (cnt_next),
        .cnt_o      (h_count)
    );

    blank_vwin #(.LINE_W(LINE_W)) u_vwin (
        .line_num   (line_num),
        .v_start    (v_start),
        .v_end      (v_end),
        .inactive_o (v_inactive)
    );

    blank_cfgchk #(.PX_W(PX_W), .MIN_TOTAL(MIN_TOTAL)) u_cfgchk (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_px (active_px),
        .total_px  (total_px),
        .byte_fmt  (byte_fmt),
        .err_o     (config_error)
    );

    always_comb begin
        st_d = st_q;
        if (enter && (cnt_next == h_start)) begin
            st_d.hblank = 1'b0;
        end
        if (enter && (cnt_next == h_end)) begin
            st_d.hblank = 1'b1;
        end
        st_d.blank = st_d.hblank || v_inactive;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{hblank: 1'b1, blank: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign blank = st_q.blank;

    AST_WHOLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        v_inactive |=> blank); // R7
    AST_END_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (enter && (cnt_next == h_end)) |=> blank); // R6
    AST_OPEN_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (enter && (cnt_next == h_start) && (cnt_next != h_end) && !v_inactive) |=> !blank); // R5
    AST_BLANK_BEFORE_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!started && !zero) |=> blank); // R2
endmodule

// File: tb/blank_gen_tb.sv
`timescale 1ns/1ps
module blank_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_ref = 1'b0;
    logic [9:0]  line_num = '0;
    logic [10:0] h_start = '0;
    logic [10:0] h_end = '0;
    logic [9:0]  v_start = '0;
    logic [9:0]  v_end = '0;
    logic [10:0] active_px = 11'd16;
    logic [10:0] total_px = 11'd16;
    logic        byte_fmt = 1'b0;
    logic        blank;
    logic [10:0] h_count;
    logic        config_error;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    blank_gen u_dut (
        .clk(clk), .rst_n(rst_n), .sync_ref(sync_ref), .line_num(line_num),
        .h_start(h_start), .h_end(h_end), .v_start(v_start), .v_end(v_end),
        .active_px(active_px), .total_px(total_px), .byte_fmt(byte_fmt),
        .blank(blank), .h_count(h_count), .config_error(config_error)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit in_window(input int l, input int lo, input int hi);
        if (lo <= hi) return (l >= lo) && (l <= hi);
        return (l >= lo) || (l <= hi);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        sync_ref = 1'b0;
        line_num = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", int'(blank), 1, "blank in reset");
        check("R1", int'(h_count), 0, "h_count in reset");
        check("R1", int'(config_error), 0, "config_error in reset");
        rst_n = 1'b1;
    endtask

    // Timing run: sync pulses every 2T clocks from edge S0, line number steps at each pulse.
    task automatic run_case(input int t, input int hs, input int he, input int vs, input int ve,
                            input int nl, input string tag);
        int s0, z, first, period, nedges;
        s0 = 5;
        period = 2 * t;
        z = period - 32;
        first = s0 + z + 1;
        nedges = s0 + nl * period;
        total_px  = 11'(t);
        active_px = 11'(t);
        byte_fmt  = 1'b0;
        h_start   = 11'(hs);
        h_end     = 11'(he);
        v_start   = 10'(vs);
        v_end     = 10'(ve);
        do_reset();
        for (int n = 1; n <= nedges; n++) begin
            int l, hc, e, ez, exp_b;
            sync_ref = (n >= s0) && (((n - s0) % period) == 0);
            l = (n < s0) ? 0 : (((n - s0) / period) % nl);
            line_num = 10'(l);
            @(posedge clk);
            @(negedge clk);
            if (n < first) begin
                check("R2", int'(h_count), 0, {tag, " h_count before origin"});
                check("R2", int'(blank), 1, {tag, " blank before origin"});
            end else begin
                ez = first + ((n - first) / period) * period;
                e  = n - ez;
                hc = e / 2;
                if (e == 0) check("R3", int'(h_count), 0, {tag, " h_count at origin"});
                else        check("R4", int'(h_count), hc, {tag, " h_count half rate"});
                if (in_window(l, vs, ve)) begin
                    if (vs > ve) check("R8", int'(blank), 1, {tag, " wrapped inactive line"});
                    else         check("R7", int'(blank), 1, {tag, " inactive line"});
                end else begin
                    exp_b = ((hc >= hs) && (hc < he)) ? 0 : 1;
                    if (exp_b == 0)   check("R5", int'(blank), 0, {tag, " active region"});
                    else if (hs == he) check("R6", int'(blank), 1, {tag, " equal edges"});
                    else              check("R6", int'(blank), 1, {tag, " horizontal blank"});
                end
            end
        end
        sync_ref = 1'b0;
    endtask

    initial begin
        run_case(20, 3, 15, 2, 3, 6, "caseA");
        run_case(32, 0, 31, 5, 5, 6, "caseB");
        run_case(24, 5, 5, 7, 7, 4, "caseC");
        run_case(18, 2, 16, 6, 1, 8, "caseD");
        do_reset();
        for (int m = 0; m < 2; m++) begin
            for (int t = 0; t < 64; t++) begin
                for (int a = 0; a < 64; a++) begin
                    int exp_e;
                    string req;
                    @(negedge clk);
                    total_px  = 11'(t);
                    active_px = 11'(a);
                    byte_fmt  = m[0];
                    exp_e = ((a % 2) != 0 || (t % 2) != 0 ||
                             (m == 1 && ((a % 4) != 0 || (t % 4) != 0)) ||
                             t < 16 || a > t) ? 1 : 0;
                    if (t < 16 || a > t)                   req = "R11";
                    else if ((a % 2) != 0 || (t % 2) != 0) req = "R9";
                    else                                    req = "R10";
                    @(posedge clk);
                    @(negedge clk);
                    check(req, int'(config_error), exp_e, "config_error");
                end
            end
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule